// File: doc/BRIEF.md
# Banked Dual Data Pointer

This block keeps two 16-bit data-memory pointers and a one-bit bank selector. The pointer that the selector picks drives the external data-memory address. The core reaches all three through a byte-wide special-function-register bus that is decoded by address.

The core also issues whole-word pointer commands: a 16-bit load and an increment. Both act only on the selected bank. An increment that the core applies to the select register flips the selector. A block copy can therefore swap between its source pointer and its destination pointer in one operation, without saving or restoring either address.

Register reads are combinational from the address. Any address the block does not own reads as zero and reports no hit.

Top module: `dual_ptr_bank`

## Requirements
- R1: After reset both pointers are 0000h, the selector is 0, `sel_out` is 0 and `mem_addr` is 0000h.
- R2: A register write to 82h sets pointer 0's low byte and a write to 83h sets its high byte. Reads of those addresses return the stored bytes with `sfr_hit` = 1.
- R3: A register write to 84h sets pointer 1's low byte and a write to 85h sets its high byte. Reads of those addresses return the stored bytes with `sfr_hit` = 1.
- R4: A write to 86h sets the selector from data bit 0 and ignores bits 7:1. A read of 86h returns {7'b0, selector} with `sfr_hit` = 1.
- R5: `sfr_inc` with address 86h inverts the selector. `sfr_inc` at any other address changes nothing in the block.
- R6: `mem_addr` always equals the pointer picked by the selector (0 picks pointer 0, 1 picks pointer 1), and `sel_out` equals the selector.
- R7: `ptr_ld` writes `ptr_ld_val` into the selected pointer only. The other pointer keeps its value.
- R8: `ptr_inc` adds one to the selected pointer, carrying from the low byte into the high byte and wrapping from FFFFh to 0000h.
- R9: When a pointer command and a register write hit the same pointer in one cycle, the command wins. When `ptr_ld` and `ptr_inc` come together, the load wins.
- R10: A read of any address other than 82h–86h returns 00h with `sfr_hit` = 0. A write there changes nothing.
- R11: Reads of 82h–85h return the stored bytes whichever bank is selected.
- R12: When a toggle and a write to 86h come in the same cycle, the toggle wins. A pointer command in the same cycle as a selector change acts on the bank that was selected before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_inc | input | 1 | Register increment strobe for the addressed location |
| sfr_rdata | output | 8 | Register read data for `sfr_addr` |
| sfr_hit | output | 1 | The address is owned by this block |
| ptr_ld | input | 1 | Load the selected pointer with `ptr_ld_val` |
| ptr_ld_val | input | 16 | Pointer load value |
| ptr_inc | input | 1 | Increment the selected pointer |
| mem_addr | output | 16 | Selected pointer, used as the data-memory address |
| sel_out | output | 1 | Current bank selector |

## Verification
The bench chases the wrap from FFFFh and the carry from 00FFh. A design that lost the carry or the wrap would leave the high byte stale or stop at FFFFh. It sets up same-cycle conflicts: a command against a byte write, a load against an increment, and a toggle against a select write. A design with the wrong priority would leave a written byte in place of the loaded word, or a selector that follows the data bit. It also checks that a command issued in the same cycle as a bank switch lands on the old bank, not the new one. Finally it sweeps every unmapped address and applies increments to pointer bytes. Sloppy decoding there would show up as nonzero read data, a false hit, or a selector that flips.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned DEF_PTR_W  = 16;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam logic [7:0]  DEF_BASE   = 8'h82;

  // Next pointer value for an increment, wrapped to w bits (w <= 32).
  function automatic logic [31:0] step_ptr(input logic [31:0] cur, input int unsigned w);
    logic [32:0] mask;
    logic [32:0] sum;
    mask = (33'h1 << w) - 33'h1;
    sum  = {1'b0, cur} + 33'h1;
    return 32'(sum & mask);
  endfunction
endpackage

// File: rtl/dptr_decode.sv
module dptr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NLANE  = 4,
  parameter logic [7:0]  BASE   = 8'h82,
  localparam int unsigned IDX_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              inc,
  output logic [NLANE-1:0]  lane_wr,
  output logic              sel_wr,
  output logic              sel_tgl,
  output logic              ptr_hit,
  output logic              sel_hit,
  output logic [IDX_W-1:0]  rd_idx
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(BASE) + ADDR_W'(NLANE);

  logic [NLANE-1:0] lane_hit;

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      assign lane_hit[g] = (addr == ADDR_W'(BASE) + ADDR_W'(g));
      assign lane_wr[g]  = lane_hit[g] & wr;
    end
  endgenerate

  assign sel_hit = (addr == SEL_ADDR);
  assign ptr_hit = |lane_hit;
  assign sel_tgl = sel_hit & inc;
  assign sel_wr  = sel_hit & wr & ~inc;

  always_comb begin
    rd_idx = '0;
    for (int i = 0; i < NLANE; i++)
      if (lane_hit[i]) rd_idx = IDX_W'(i);
  end

  always_comb begin
    a_lane_onehot_r10: assert ($onehot0({lane_hit, sel_hit}));
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = PTR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lane_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cmd_ld,
  input  logic              cmd_inc,
  input  logic [PTR_W-1:0]  ld_val,
  output logic [PTR_W-1:0]  val
);
  logic [31:0]      stepped;
  logic [PTR_W-1:0] nxt;
  logic             cmd_any;
  logic             byte_blocked;

  assign cmd_any      = cmd_ld | cmd_inc;
  assign byte_blocked = cmd_any & (|lane_wr);

  always_comb begin
    stepped = dptr_pkg::step_ptr(32'(val), PTR_W);
    nxt     = val;
    if (cmd_ld)       nxt = ld_val;
    else if (cmd_inc) nxt = stepped[PTR_W-1:0];
    else begin
      for (int l = 0; l < NB; l++)
        if (lane_wr[l]) nxt[l*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end

  p_ld_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ld |=> val == $past(ld_val));
  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inc && !cmd_ld) |=> val == PTR_W'($past(val) + 1'b1));
  p_cmd_over_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_blocked && !cmd_ld) |=> val == PTR_W'($past(val) + 1'b1));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_any && lane_wr == '0) |=> $stable(val));
endmodule

// File: rtl/dptr_select.sv
module dptr_select (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_wr,
  input  logic sel_wbit,
  input  logic sel_tgl,
  output logic sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel <= 1'b0;
    else if (sel_tgl) sel <= ~sel;
    else if (sel_wr)  sel <= sel_wbit;
  end

  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tgl |=> sel != $past(sel));
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_tgl && !sel_wr) |=> $stable(sel));
endmodule

// File: rtl/dual_ptr_bank.sv
module dual_ptr_bank #(
  parameter int unsigned PTR_W  = dptr_pkg::DEF_PTR_W,
  parameter int unsigned BYTE_W = dptr_pkg::DEF_BYTE_W,
  parameter int unsigned ADDR_W = dptr_pkg::DEF_ADDR_W,
  parameter logic [7:0]  BASE   = dptr_pkg::DEF_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [BYTE_W-1:0] sfr_wdata,
  input  logic              sfr_inc,
  output logic [BYTE_W-1:0] sfr_rdata,
  output logic              sfr_hit,
  input  logic              ptr_ld,
  input  logic [PTR_W-1:0]  ptr_ld_val,
  input  logic              ptr_inc,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              sel_out
);
  localparam int unsigned NB    = PTR_W / BYTE_W;
  localparam int unsigned NBANK = 2;
  localparam int unsigned NLANE = NB * NBANK;
  localparam int unsigned IDX_W = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [NLANE-1:0]       lane_wr;
  logic                   sel_wr, sel_tgl, ptr_hit, sel_hit;
  logic [IDX_W-1:0]       rd_idx;
  logic                   sel;
  logic [NBANK*PTR_W-1:0] ptr_flat;
  logic [NBANK-1:0]       bank_active;

  dptr_decode #(.ADDR_W(ADDR_W), .NLANE(NLANE), .BASE(BASE)) u_dec (
    .addr(sfr_addr), .wr(sfr_wr), .inc(sfr_inc),
    .lane_wr(lane_wr), .sel_wr(sel_wr), .sel_tgl(sel_tgl),
    .ptr_hit(ptr_hit), .sel_hit(sel_hit), .rd_idx(rd_idx)
  );

  dptr_select u_sel (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wbit(sfr_wdata[0]),
    .sel_tgl(sel_tgl), .sel(sel)
  );

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      assign bank_active[b] = (sel == 1'(b));
      dptr_bank #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .lane_wr(lane_wr[b*NB +: NB]), .wdata(sfr_wdata),
        .cmd_ld(ptr_ld & bank_active[b]), .cmd_inc(ptr_inc & bank_active[b]),
        .ld_val(ptr_ld_val), .val(ptr_flat[b*PTR_W +: PTR_W])
      );
    end
  endgenerate

  always_comb begin
    if (sel_hit)      sfr_rdata = BYTE_W'(sel);
    else if (ptr_hit) sfr_rdata = ptr_flat[rd_idx*BYTE_W +: BYTE_W];
    else              sfr_rdata = '0;
  end

  assign sfr_hit  = sel_hit | ptr_hit;
  assign mem_addr = ptr_flat[sel*PTR_W +: PTR_W];
  assign sel_out  = sel;

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_hit |-> sfr_rdata == '0);
  p_one_bank_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bank_active));
  p_sel_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> sfr_rdata[BYTE_W-1:1] == '0);
endmodule

// File: tb/sim_dual_ptr_bank.sv
module sim_dual_ptr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic        sfr_inc = 1'b0;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic        ptr_ld = 1'b0;
  logic [15:0] ptr_ld_val = 16'h0;
  logic        ptr_inc = 1'b0;
  logic [15:0] mem_addr;
  logic        sel_out;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] mp [2];
  logic        ms;

  always #4 clk = ~clk;

  dual_ptr_bank u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_inc(sfr_inc), .sfr_rdata(sfr_rdata),
    .sfr_hit(sfr_hit), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
    .ptr_inc(ptr_inc), .mem_addr(mem_addr), .sel_out(sel_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reads all owned addresses through the bus, plus the address outputs.
  task automatic verify_all(input string req);
    check({req, "/R6 mem_addr"}, 32'(mem_addr), 32'(ms ? mp[1] : mp[0]));
    check({req, "/R6 sel_out"}, 32'(sel_out), 32'(ms));
    for (int a = 0; a < 5; a++) begin
      logic [7:0] exp;
      if (a == 4) exp = {7'b0, ms};
      else        exp = mp[a/2][(a%2)*8 +: 8];
      sfr_addr = 8'h82 + 8'(a);
      #1;
      check({req, "/R11 read"}, {23'b0, sfr_hit, sfr_rdata}, {23'b0, 1'b1, exp});
    end
    sfr_addr = 8'h00;
  endtask

  task automatic drive(input logic [7:0] a, input logic w, input logic [7:0] wd,
                       input logic i, input logic l, input logic [15:0] lv,
                       input logic p, input string req);
    logic [15:0] np [2];
    logic        nsel;
    sfr_addr = a; sfr_wr = w; sfr_wdata = wd; sfr_inc = i;
    ptr_ld = l; ptr_ld_val = lv; ptr_inc = p;
    @(posedge clk);
    np[0] = mp[0]; np[1] = mp[1]; nsel = ms;
    if (w && a >= 8'h82 && a <= 8'h85) begin
      int bk, ln;
      bk = int'(a - 8'h82) / 2;
      ln = int'(a - 8'h82) % 2;
      if (!((l || p) && bk == int'(ms))) np[bk][ln*8 +: 8] = wd;
    end
    if (l)      np[ms] = lv;
    else if (p) np[ms] = mp[ms] + 16'd1;
    if (i && a == 8'h86)      nsel = ~ms;
    else if (w && a == 8'h86) nsel = wd[0];
    mp[0] = np[0]; mp[1] = np[1]; ms = nsel;
    @(negedge clk);
    sfr_wr = 0; sfr_inc = 0; ptr_ld = 0; ptr_inc = 0; sfr_addr = 8'h00;
    verify_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    mp[0] = 16'h0; mp[1] = 16'h0; ms = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    verify_all("R1");

    drive(8'h82, 1, 8'h34, 0, 0, 16'h0, 0, "R2");
    drive(8'h83, 1, 8'h12, 0, 0, 16'h0, 0, "R2");
    drive(8'h84, 1, 8'hCD, 0, 0, 16'h0, 0, "R3");
    drive(8'h85, 1, 8'hAB, 0, 0, 16'h0, 0, "R3");
    drive(8'h86, 1, 8'hFF, 0, 0, 16'h0, 0, "R4");
    drive(8'h86, 1, 8'hFE, 0, 0, 16'h0, 0, "R4");
    drive(8'h86, 0, 8'h00, 1, 0, 16'h0, 0, "R5");
    drive(8'h83, 0, 8'h00, 1, 0, 16'h0, 0, "R5");
    drive(8'h86, 0, 8'h00, 1, 0, 16'h0, 0, "R5");
    drive(8'h00, 0, 8'h00, 0, 1, 16'hFFFE, 0, "R7");
    drive(8'h00, 0, 8'h00, 0, 0, 16'h0, 1, "R8");
    drive(8'h00, 0, 8'h00, 0, 0, 16'h0, 1, "R8");
    check("R8 wrap", 32'(mem_addr), 32'h0000);
    drive(8'h00, 0, 8'h00, 0, 1, 16'h00FF, 0, "R7");
    drive(8'h00, 0, 8'h00, 0, 0, 16'h0, 1, "R8");
    check("R8 carry", 32'(mem_addr), 32'h0100);
    drive(8'h86, 0, 8'h00, 1, 0, 16'h0, 0, "R5");
    drive(8'h00, 0, 8'h00, 0, 1, 16'h5A5A, 0, "R7");
    drive(8'h84, 1, 8'h77, 0, 0, 16'h0, 1, "R9");
    drive(8'h85, 1, 8'h77, 0, 1, 16'h1357, 0, "R9");
    drive(8'h00, 0, 8'h00, 0, 1, 16'h2468, 1, "R9");
    drive(8'h82, 1, 8'h99, 0, 1, 16'hBEEF, 0, "R9");
    drive(8'h86, 1, 8'h01, 1, 0, 16'h0, 0, "R12");
    drive(8'h86, 0, 8'h00, 1, 1, 16'hC0DE, 0, "R12");
    drive(8'h86, 1, 8'h00, 0, 0, 16'h0, 1, "R12");
    drive(8'h87, 1, 8'hFF, 1, 0, 16'h0, 0, "R10");
    drive(8'h81, 1, 8'h55, 0, 0, 16'h0, 0, "R10");

    for (int a = 0; a < 256; a++) begin
      if (a < 8'h82 || a > 8'h86) begin
        sfr_addr = 8'(a);
        #1;
        check("R10 unmapped read", {23'b0, sfr_hit, sfr_rdata}, 32'h0);
      end
    end
    sfr_addr = 8'h00;

    lf = 32'hACE1_2357;
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] lv;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lv = lf[4] ? 16'hFFFF : lf[31:16];
      drive(8'h80 + 8'(lf[2:0]), lf[3], lf[15:8], lf[5] & lf[6],
            lf[7] & lf[8], lv, lf[9] & lf[10], "R7/R8/R9 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule